// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block computes the next program address for a small 8-bit controller core with a 16-bit program space, and it holds the program counter register. Each cycle the decoder supplies a target mode, the length of the current instruction and the operand fields that the instruction carries. The block forms the address of the byte after the instruction and builds every candidate target from that base or from the operands. It then tests the accumulator for the two zero-conditional forms and selects the address that the counter loads when `step` is high.

There are four target formats. The first is a signed 8-bit displacement from the following instruction. The second is an 11-bit field that replaces the low bits of the following address, so the target stays inside the same 2 KB page. The third is a full 16-bit address. The fourth is the sum of the accumulator and the data pointer. A return takes the address popped from the stack. For the two call forms the block gives the stack the address of the following instruction and raises a push strobe. The zero test reads the accumulator value directly. There is no stored flag.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x0000. After reset is released, `pc` changes only on a rising clock edge with `step` high, and then it loads the value that `next_pc` held before that edge.
- R2: Mode code 0 (sequential): `next_pc` = (`pc` + `instr_len`) mod 65536, where `instr_len` is the instruction byte count (1 to 3).
- R3: Mode code 1 (relative): `next_pc` = the sequential address plus `rel_off` read as an 8-bit two's-complement value (-128 to +127). With `rel_off` = 0xFE and `instr_len` = 2, the target is `pc` itself.
- R4: Mode code 2 (page): `next_pc` keeps bits 15:11 of the sequential address and takes bits 10:0 from `page_off`. If the sequential address has crossed into the next page, that page is the one used.
- R5: Mode code 3 (long): `next_pc` = `long_addr`.
- R6: Mode code 4 (indexed): `next_pc` = (zero-extended `acc` + `dptr`) mod 65536.
- R7: Mode code 5 (return): `next_pc` = `stack_addr`.
- R8: Mode codes 6 (jump if zero) and 7 (jump if not zero) take the relative target only when `acc` == 0 (code 6) or when `acc` != 0 (code 7). Otherwise they take the sequential address. The output `taken` is high exactly when a non-sequential target is selected.
- R9: `ret_addr` always equals the sequential address. `push` is high exactly when `step` and `call_req` are high and the mode is 2 or 3. In every other mode `call_req` has no effect.
- R10: All address arithmetic wraps modulo 65536. For example, 0xFFFF with length 1 goes to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Load next_pc into pc on this edge |
| mode | input | 3 | Target mode code (0 to 7, see requirements) |
| instr_len | input | 2 | Byte length of the current instruction |
| call_req | input | 1 | Current page or long transfer is a call |
| rel_off | input | 8 | Signed relative displacement |
| page_off | input | 11 | In-page target bits |
| long_addr | input | 16 | Full target address |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| stack_addr | input | 16 | Address popped from the stack |
| pc | output | 16 | Program counter register |
| next_pc | output | 16 | Selected next address |
| taken | output | 1 | A non-sequential target is selected |
| ret_addr | output | 16 | Return address offered to the stack |
| push | output | 1 | Stack push strobe for calls |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, an 8-bit accumulator and an 11-bit page field. These widths make the wrap at 0xFFFF, page crossings at 2 KB multiples and the full signed displacement range easy to reach with directed steps. Random sequences then move the counter across the whole space. An accumulator drawn from a range biased toward zero exercises both outcomes of the two conditional modes.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_SEQ   = 3'd0,
    M_REL   = 3'd1,
    M_PAGE  = 3'd2,
    M_LONG  = 3'd3,
    M_INDEX = 3'd4,
    M_RET   = 3'd5,
    M_JZ    = 3'd6,
    M_JNZ   = 3'd7
  } pc_mode_e;

  typedef enum logic [2:0] {
    SRC_SEQ, SRC_REL, SRC_PAGE, SRC_LONG, SRC_INDEX, SRC_RET
  } pc_src_e;
endpackage

// File: rtl/pcn_target.sv
module pcn_target #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PW = 11,
  parameter int LW = 2
) (
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] off,
  input  logic [PW-1:0] page_low,
  input  logic [AW-1:0] long_tgt,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic [AW-1:0] stack,
  output logic [AW-1:0] seq_a,
  output logic [AW-1:0] rel_a,
  output logic [AW-1:0] page_a,
  output logic [AW-1:0] long_a,
  output logic [AW-1:0] idx_a,
  output logic [AW-1:0] ret_a
);
  localparam int HI_W = AW - PW;

  function automatic logic [AW-1:0] f_seq(input logic [AW-1:0] p, input logic [LW-1:0] n);
    return p + AW'(n);
  endfunction

  function automatic logic [AW-1:0] f_rel(input logic [AW-1:0] b, input logic [DW-1:0] d);
    logic [AW-1:0] ext;
    ext = {{(AW-DW){d[DW-1]}}, d};
    return b + ext;
  endfunction

  function automatic logic [AW-1:0] f_page(input logic [AW-1:0] b, input logic [PW-1:0] lo);
    return {b[AW-1 -: HI_W], lo};
  endfunction

  function automatic logic [AW-1:0] f_idx(input logic [DW-1:0] a, input logic [AW-1:0] d);
    return AW'(a) + d;
  endfunction

  always_comb begin
    seq_a  = f_seq(pc, len);
    rel_a  = f_rel(seq_a, off);
    page_a = f_page(seq_a, page_low);
    long_a = long_tgt;
    idx_a  = f_idx(acc, dptr);
    ret_a  = stack;
  end

  // The page target keeps the page of the following address.
  always_comb begin
    assert_page_keep_R4: assert (page_a[AW-1 -: HI_W] == seq_a[AW-1 -: HI_W]);
  end
endmodule

// File: rtl/pcn_cond.sv
module pcn_cond #(
  parameter int DW = 8
) (
  input  pcn_pkg::pc_mode_e mode,
  input  logic [DW-1:0]     acc,
  output logic              acc_zero,
  output pcn_pkg::pc_src_e  src,
  output logic              taken
);
  import pcn_pkg::*;

  // The zero test is a reduction over the accumulator. For wide
  // accumulators it is built as a two-level tree.
  generate
    if (DW > 8) begin : g_tree
      localparam int NG = (DW + 7) / 8;
      logic [NG-1:0] grp_nz;
      for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * 8;
        localparam int HI = (LO + 7 < DW) ? LO + 7 : DW - 1;
        assign grp_nz[g] = |acc[HI:LO];
      end
      assign acc_zero = ~|grp_nz;
    end else begin : g_flat
      assign acc_zero = ~|acc;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      M_SEQ:   src = SRC_SEQ;
      M_REL:   src = SRC_REL;
      M_PAGE:  src = SRC_PAGE;
      M_LONG:  src = SRC_LONG;
      M_INDEX: src = SRC_INDEX;
      M_RET:   src = SRC_RET;
      M_JZ:    src = acc_zero ? SRC_REL : SRC_SEQ;
      M_JNZ:   src = acc_zero ? SRC_SEQ : SRC_REL;
      default: src = SRC_SEQ;
    endcase
    taken = (src != SRC_SEQ);
  end

  // The two conditional modes take the branch on opposite accumulator values.
  always_comb begin
    if (mode == M_JZ)  assert_jz_cond_R8:  assert (taken == (acc == '0));
    if (mode == M_JNZ) assert_jnz_cond_R8: assert (taken == (acc != '0));
    if (mode == M_SEQ) assert_seq_not_taken_R2: assert (!taken);
  end
endmodule

// File: rtl/pcn_select.sv
module pcn_select #(
  parameter int AW = 16
) (
  input  pcn_pkg::pc_src_e src,
  input  logic [AW-1:0]    seq_a,
  input  logic [AW-1:0]    rel_a,
  input  logic [AW-1:0]    page_a,
  input  logic [AW-1:0]    long_a,
  input  logic [AW-1:0]    idx_a,
  input  logic [AW-1:0]    ret_a,
  output logic [AW-1:0]    nxt
);
  import pcn_pkg::*;

  always_comb begin
    unique case (src)
      SRC_REL:   nxt = rel_a;
      SRC_PAGE:  nxt = page_a;
      SRC_LONG:  nxt = long_a;
      SRC_INDEX: nxt = idx_a;
      SRC_RET:   nxt = ret_a;
      default:   nxt = seq_a;
    endcase
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic [pcn_pkg::MODE_W-1:0] mode,
  input  logic [LEN_W-1:0]           instr_len,
  input  logic                       call_req,
  input  logic [DATA_W-1:0]          rel_off,
  input  logic [PAGE_W-1:0]          page_off,
  input  logic [ADDR_W-1:0]          long_addr,
  input  logic [DATA_W-1:0]          acc,
  input  logic [ADDR_W-1:0]          dptr,
  input  logic [ADDR_W-1:0]          stack_addr,
  output logic [ADDR_W-1:0]          pc,
  output logic [ADDR_W-1:0]          next_pc,
  output logic                       taken,
  output logic [ADDR_W-1:0]          ret_addr,
  output logic                       push
);
  import pcn_pkg::*;

  pc_mode_e         mode_e;
  pc_src_e          src;
  logic             acc_zero;
  logic             is_call_form;
  logic [ADDR_W-1:0] seq_a, rel_a, page_a, long_a, idx_a, ret_a;
  logic [ADDR_W-1:0] pc_q;

  assign mode_e = pc_mode_e'(mode);

  pcn_target #(.AW(ADDR_W), .DW(DATA_W), .PW(PAGE_W), .LW(LEN_W)) u_tgt (
    .pc(pc_q), .len(instr_len), .off(rel_off), .page_low(page_off),
    .long_tgt(long_addr), .acc(acc), .dptr(dptr), .stack(stack_addr),
    .seq_a(seq_a), .rel_a(rel_a), .page_a(page_a), .long_a(long_a),
    .idx_a(idx_a), .ret_a(ret_a)
  );

  pcn_cond #(.DW(DATA_W)) u_cond (
    .mode(mode_e), .acc(acc), .acc_zero(acc_zero), .src(src), .taken(taken)
  );

  pcn_select #(.AW(ADDR_W)) u_sel (
    .src(src), .seq_a(seq_a), .rel_a(rel_a), .page_a(page_a),
    .long_a(long_a), .idx_a(idx_a), .ret_a(ret_a), .nxt(next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (step) pc_q <= next_pc;
  end

  assign is_call_form = (mode_e == M_PAGE) || (mode_e == M_LONG);
  assign push         = step && call_req && is_call_form;
  assign ret_addr     = seq_a;
  assign pc           = pc_q;

  // Check that the register follows the selected address and holds otherwise.
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(step) |-> pc == $past(next_pc));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(step) |-> $stable(pc));
  assert_ret_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_e == M_RET |-> next_pc == stack_addr && taken);
  assert_push_form_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> step && (mode_e == M_PAGE || mode_e == M_LONG));
  assert_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_e == M_LONG |-> next_pc == long_addr);
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, step = 0, call_req = 0;
  logic [2:0]  mode = 0;
  logic [1:0]  instr_len = 1;
  logic [7:0]  rel_off = 0, acc = 0;
  logic [10:0] page_off = 0;
  logic [15:0] long_addr = 0, dptr = 0, stack_addr = 0;
  logic [15:0] pc, next_pc, ret_addr;
  logic        taken, push;

  int checks = 0, errors = 0;
  bit done = 0;

  pc_next_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_seq(input logic [15:0] p, input int n);
    return 16'((int'(p) + n) % 65536);
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] p, input int m, input int n,
      input logic [7:0] o, input logic [10:0] lo, input logic [15:0] la,
      input logic [7:0] a, input logic [15:0] d, input logic [15:0] st, output bit tk);
    int s, r;
    s = int'(exp_seq(p, n));
    r = (s + int'($signed(o)) + 65536) % 65536;
    tk = 1;
    case (m)
      0: begin tk = 0; return 16'(s); end
      1: return 16'(r);
      2: return 16'((s / 2048) * 2048 + int'(lo));
      3: return la;
      4: return 16'((int'(a) + int'(d)) % 65536);
      5: return st;
      6: begin tk = (a == 0); return tk ? 16'(r) : 16'(s); end
      default: begin tk = (a != 0); return tk ? 16'(r) : 16'(s); end
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one instruction at the falling edge, check the combinational
  // outputs, then check the register after the next rising edge.
  task automatic run(input int m, input int n, input logic [7:0] o, input logic [10:0] lo,
      input logic [15:0] la, input logic [7:0] a, input logic [15:0] d,
      input logic [15:0] st, input bit cr, input bit stp, input string req);
    logic [15:0] e, p0;
    bit tk;
    p0 = pc;
    mode = 3'(m); instr_len = 2'(n); rel_off = o; page_off = lo;
    long_addr = la; acc = a; dptr = d; stack_addr = st; call_req = cr; step = stp;
    #1;
    e = exp_next(p0, m, n, o, lo, la, a, d, st, tk);
    chk(req, next_pc, e);
    chk({req, " taken"}, taken, tk);
    chk("R9 ret", ret_addr, exp_seq(p0, n));
    chk("R9 push", push, stp && cr && (m == 2 || m == 3));
    @(negedge clk);
    chk({req, " pc R1"}, pc, stp ? e : p0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    chk("R1 reset", pc, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", pc, 16'h0000);

    run(3, 3, 0, 0, 16'hFFFF, 0, 0, 0, 0, 1, "R5 long to top");
    run(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R10 wrap seq R2");
    run(3, 3, 0, 0, 16'h1234, 0, 0, 0, 1, 1, "R5 long call");
    run(1, 2, 8'hFE, 0, 0, 0, 0, 0, 0, 1, "R3 self loop");
    run(1, 2, 8'h80, 0, 0, 0, 0, 0, 0, 1, "R3 back 128");
    run(1, 2, 8'h7F, 0, 0, 0, 0, 0, 0, 1, "R3 fwd 127");
    run(3, 3, 0, 0, 16'h07FF, 0, 0, 0, 0, 1, "R5 long edge");
    run(2, 2, 0, 11'h005, 0, 0, 0, 0, 1, 1, "R4 page crossing");
    run(4, 1, 0, 0, 0, 8'hFF, 16'hFF80, 0, 0, 1, "R6 index wrap R10");
    run(5, 1, 0, 0, 0, 0, 0, 16'hBEEF, 0, 1, "R7 return");
    run(6, 2, 8'h10, 0, 0, 8'h00, 0, 0, 0, 1, "R8 jz taken");
    run(6, 2, 8'h10, 0, 0, 8'h01, 0, 0, 0, 1, "R8 jz not taken");
    run(7, 2, 8'hF0, 0, 0, 8'h80, 0, 0, 0, 1, "R8 jnz taken");
    run(7, 2, 8'hF0, 0, 0, 8'h00, 0, 0, 0, 1, "R8 jnz not taken");
    run(1, 2, 8'h40, 0, 0, 0, 0, 0, 1, 1, "R9 call ignored in rel");
    run(3, 3, 0, 0, 16'h5555, 0, 0, 0, 1, 0, "R1 hold no step");

    for (int i = 0; i < 3000; i++) begin
      int m = int'($urandom_range(0, 7));
      int n = int'($urandom_range(1, 3));
      logic [7:0] a = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      run(m, n, 8'($urandom), 11'($urandom), 16'($urandom), a, 16'($urandom),
          16'($urandom), 1'($urandom), ($urandom_range(0, 5) != 0), "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule